// File: doc/BRIEF.md
# Handshaked DMA Word Transfer Sequencer

This block moves data words between a serial-bus remote terminal core and an external 16-bit system data bus. The core asks for a transfer. For a write to the system it also gives a burst flag and a word count. The block then takes the system bus through an active-low request/grant handshake. Once the grant is seen, it produces the write strobe and read output-enable pulses with fixed, cycle-exact shapes. An active-low acknowledge frames the whole time the data bus is in use.

A transfer that moves data into the core (a read) always moves one word. A write without the burst flag also moves one word. A burst write needs only one handshake. After it, the acknowledge stays low for three clocks per word. The core supplies the data for the word index that the block presents. If the grant does not arrive within a timeout, the block gives up the request, returns to idle and raises a sticky fail indication. The timeout is derived from the clock frequency and a time limit in microseconds.

The system data bus is split into an output vector, an output enable and an input vector, so that the pad tristate can be placed at the chip edge.

Top module: `dma_xfer_seq`

## Requirements
- R1: While reset is active and after it, `bus_req_n`, `bus_ack_n`, `wr_stb_n`, `rd_oe_n` and `hs_fail_n` are high, and `sys_dout_en`, `busy`, `xfer_done` and `rd_valid` are low.
- R2: Starting a transfer:
  - When `xfer_start` is sampled high in idle, `bus_req_n` goes low in the next cycle.
  - `bus_ack_n` stays high for as long as the grant has not been sampled low.
- R3: Grant acceptance:
  - When `bus_gnt_n` is sampled low while requesting, in the next cycle `bus_req_n` is high and `bus_ack_n` is low.
  - With the grant held low, the request lasts exactly one cycle.
  - `bus_req_n` and `bus_ack_n` are never low together.
- R4: Write transfers:
  - Each word occupies a slot of three clocks, and `wr_stb_n` is low only in the second clock of the slot.
  - `sys_dout_en` is high exactly while `bus_ack_n` is low during a write.
  - `sys_dout` equals `wr_data`.
- R5: Read transfers:
  - `rd_oe_n` is low for the three clocks of the slot.
  - `rd_data` takes the `sys_din` value present in the second clock of the slot.
  - `rd_valid` pulses high during the third clock of the slot.
- R6: A read, or a write without the burst flag, moves exactly one word with its own handshake. The burst flag and the count are ignored in those cases.
- R7: Burst writes:
  - A burst write of N words (`xfer_count` = N, where 0 counts as 1) holds `bus_ack_n` low for 3*N consecutive clocks.
  - `word_idx` steps 0..N-1, advancing every three clocks.
- R8: Grant timeout:
  - The timeout is TMO_CYC = CLK_KHZ*TMO_US/1000 cycles.
  - If the grant is not sampled low at any of the TMO_CYC edges after the request goes low, the request is released and `hs_fail_n` goes low in the same cycle.
  - The block then returns to idle without asserting `bus_ack_n`.
  - A grant sampled at the last of those edges still wins.
- R9: After a timeout, `hs_fail_n` stays low until the next accepted `xfer_start`, and goes high in the cycle after it.
- R10: `xfer_start` and the transfer attributes are ignored while `busy` is high. The transfer in progress keeps its shape.
- R11: `busy` is high from the cycle after acceptance to the end of the transfer. `xfer_done` pulses for one cycle, in the first idle cycle after the last slot of a transfer that completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_start | input | 1 | Transfer request from the core, sampled in idle |
| xfer_write | input | 1 | 1: core to system (write), 0: system to core (read) |
| xfer_burst | input | 1 | Burst mode for writes |
| xfer_count | input | CNT_W | Burst word count, 0 means one word |
| wr_data | input | DATA_W | Write data for the word at `word_idx` |
| word_idx | output | CNT_W | Index of the word in the current slot |
| rd_data | output | DATA_W | Last word read from the system |
| rd_valid | output | 1 | One-cycle pulse when `rd_data` is updated |
| xfer_done | output | 1 | One-cycle pulse on completion |
| busy | output | 1 | Transfer in progress |
| bus_req_n | output | 1 | Active-low bus request |
| bus_gnt_n | input | 1 | Active-low bus grant |
| bus_ack_n | output | 1 | Active-low acknowledge framing the data phase |
| wr_stb_n | output | 1 | Active-low one-clock write strobe |
| rd_oe_n | output | 1 | Active-low read output enable |
| hs_fail_n | output | 1 | Active-low sticky handshake timeout flag |
| sys_dout | output | DATA_W | System bus output data |
| sys_dout_en | output | 1 | System bus output drive enable |
| sys_din | input | DATA_W | System bus input data |

## Verification
The assertions check the following on every cycle:
- request and acknowledge are never low together;
- the write strobe is one clock wide and falls inside a driven write acknowledge;
- the output enable only appears under the acknowledge;
- the fail flag falls together with the request release and holds until a new start;
- the grant counter and the slot phase stay in range;
- the word index holds inside a slot.

Only the bench scenarios can show the following:
- the exact cycle-by-cycle shape of each transfer against the grant delay and the word count;
- that a grant on the last timeout edge still wins;
- which input word is captured on a read;
- that a start raised mid-transfer leaves the transfer unchanged.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_XFER = 2'd2
    } xfer_st_e;

    localparam int SLOT_CYC = 3;
    localparam int PH_W     = $clog2(SLOT_CYC);
endpackage

// File: rtl/dma_gnt_timer.sv
module dma_gnt_timer #(
    parameter int TMO_CYC = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(TMO_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t r_q, r_d;

    assign expired = run && (r_q.cnt == CW'(TMO_CYC - 1));

    always_comb begin
        r_d = r_q;
        if (run && !expired) r_d.cnt = r_q.cnt + 1'b1;
        else                 r_d.cnt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R8
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt < CW'(TMO_CYC));
endmodule

// File: rtl/dma_slot_seq.sv
module dma_slot_seq
    import dma_xfer_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] last_idx,
    output logic [PH_W-1:0]  phase,
    output logic [CNT_W-1:0] word_idx,
    output logic             slot_end,
    output logic             last_end
);
    typedef struct packed {
        logic [PH_W-1:0]  ph;
        logic [CNT_W-1:0] idx;
    } slot_t;

    slot_t r_q, r_d;

    assign phase    = r_q.ph;
    assign word_idx = r_q.idx;
    assign slot_end = run && (r_q.ph == PH_W'(SLOT_CYC - 1));
    assign last_end = slot_end && (r_q.idx == last_idx);

    always_comb begin
        r_d = r_q;
        if (run && !last_end) begin
            r_d.ph = slot_end ? '0 : r_q.ph + 1'b1;
            if (slot_end) r_d.idx = r_q.idx + 1'b1;
        end else begin
            r_d.ph  = '0;
            r_d.idx = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R7
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ph < PH_W'(SLOT_CYC));

    // R7
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !slot_end) |=> $stable(word_idx));
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
    import dma_xfer_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int CNT_W   = 6,
    parameter int CLK_KHZ = 125000,
    parameter int TMO_US  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_start,
    input  logic              xfer_write,
    input  logic              xfer_burst,
    input  logic [CNT_W-1:0]  xfer_count,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  word_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              xfer_done,
    output logic              busy,
    output logic              bus_req_n,
    input  logic              bus_gnt_n,
    output logic              bus_ack_n,
    output logic              wr_stb_n,
    output logic              rd_oe_n,
    output logic              hs_fail_n,
    output logic [DATA_W-1:0] sys_dout,
    output logic              sys_dout_en,
    input  logic [DATA_W-1:0] sys_din
);
    localparam int TMO_CYC = CLK_KHZ * TMO_US / 1000;

    typedef struct packed {
        xfer_st_e          st;
        logic              wr;
        logic [CNT_W-1:0]  last_idx;
        logic              fail_n;
        logic              done;
        logic [DATA_W-1:0] rdat;
        logic              rvld;
    } seq_t;

    seq_t r_q, r_d;

    logic            tmo_exp;
    logic [PH_W-1:0] phase;
    logic            slot_end;
    logic            last_end;

    dma_gnt_timer #(.TMO_CYC(TMO_CYC)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (r_q.st == ST_REQ),
        .expired (tmo_exp)
    );

    dma_slot_seq #(.CNT_W(CNT_W)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (r_q.st == ST_XFER),
        .last_idx (r_q.last_idx),
        .phase    (phase),
        .word_idx (word_idx),
        .slot_end (slot_end),
        .last_end (last_end)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.rvld = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (xfer_start) begin
                    r_d.st     = ST_REQ;
                    r_d.wr     = xfer_write;
                    r_d.fail_n = 1'b1;
                    if (xfer_write && xfer_burst && (xfer_count != '0))
                        r_d.last_idx = xfer_count - 1'b1;
                    else
                        r_d.last_idx = '0;
                end
            end
            ST_REQ: begin
                if (!bus_gnt_n) begin
                    r_d.st = ST_XFER;
                end else if (tmo_exp) begin
                    r_d.st     = ST_IDLE;
                    r_d.fail_n = 1'b0;
                end
            end
            ST_XFER: begin
                if (!r_q.wr && (phase == PH_W'(1))) begin
                    r_d.rdat = sys_din;
                    r_d.rvld = 1'b1;
                end
                if (last_end) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= ST_IDLE;
            r_q.fail_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy        = (r_q.st != ST_IDLE);
    assign bus_req_n   = !(r_q.st == ST_REQ);
    assign bus_ack_n   = !(r_q.st == ST_XFER);
    assign wr_stb_n    = !((r_q.st == ST_XFER) && r_q.wr && (phase == PH_W'(1)));
    assign rd_oe_n     = !((r_q.st == ST_XFER) && !r_q.wr);
    assign sys_dout_en = (r_q.st == ST_XFER) && r_q.wr;
    assign sys_dout    = wr_data;
    assign hs_fail_n   = r_q.fail_n;
    assign xfer_done   = r_q.done;
    assign rd_data     = r_q.rdat;
    assign rd_valid    = r_q.rvld;

    // R3
    req_ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_req_n && !bus_ack_n));

    // R4
    stb_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb_n |-> (!bus_ack_n && sys_dout_en));

    // R4
    stb_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb_n |=> wr_stb_n);

    // R5
    oe_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_oe_n |-> !bus_ack_n);

    // R8
    fail_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_fail_n) |-> $rose(bus_req_n));

    // R9
    fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_fail_n && !xfer_start) |=> !hs_fail_n);

    // R10
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !slot_end && bus_gnt_n && !tmo_exp) |=> busy);
endmodule

// File: tb/dma_xfer_seq_bench.sv
module dma_xfer_seq_bench;
    localparam int DW  = 16;
    localparam int CW  = 6;
    localparam int TMO = 125000 * 10 / 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          xfer_start = 0, xfer_write = 0, xfer_burst = 0;
    logic [CW-1:0] xfer_count = '0;
    logic [DW-1:0] wr_data, rd_data, sys_dout;
    logic [DW-1:0] sys_din = '0;
    logic [DW-1:0] salt = '0;
    logic [CW-1:0] word_idx;
    logic          rd_valid, xfer_done, busy, bus_req_n, bus_ack_n;
    logic          wr_stb_n, rd_oe_n, hs_fail_n, sys_dout_en;
    logic          bus_gnt_n = 1'b1;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    bit prev_to = 0;

    function automatic logic [DW-1:0] wd(input int w);
        return 16'h5A00 ^ 16'(w * 291);
    endfunction

    assign wr_data = wd(int'(word_idx)) ^ salt;

    dma_xfer_seq u_dma_xfer_seq (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_write(xfer_write),
        .xfer_burst(xfer_burst), .xfer_count(xfer_count), .wr_data(wr_data),
        .word_idx(word_idx), .rd_data(rd_data), .rd_valid(rd_valid),
        .xfer_done(xfer_done), .busy(busy), .bus_req_n(bus_req_n),
        .bus_gnt_n(bus_gnt_n), .bus_ack_n(bus_ack_n), .wr_stb_n(wr_stb_n),
        .rd_oe_n(rd_oe_n), .hs_fail_n(hs_fail_n), .sys_dout(sys_dout),
        .sys_dout_en(sys_dout_en), .sys_din(sys_din)
    );

    task automatic chk(input string tag, input logic [31:0] act,
                       input logic [31:0] exp, input int c);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s cycle %0d act=%h exp=%h", tag, c, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    task automatic run_xfer(input bit wr, input bit bu, input int cnt,
                            input int dly, input bit poke);
        bit            to;
        int            nw, g, s, fin, ph, w;
        logic          ackx;
        logic [DW-1:0] din_rec;
        to      = (dly >= TMO);
        nw      = (wr && bu) ? ((cnt == 0) ? 1 : cnt) : 1;
        g       = to ? TMO : 1 + dly;
        s       = g + 1;
        fin     = to ? g + 1 : s + 3 * nw;
        din_rec = '0;
        @(negedge clk);
        chk("R9 fail held before start", hs_fail_n, !prev_to, 0);
        chk("R11 idle before start", busy, 0, 0);
        xfer_start = 1;
        xfer_write = wr;
        xfer_burst = bu;
        xfer_count = cnt[CW-1:0];
        bus_gnt_n  = !(dly == 0);
        salt       = 16'($urandom);
        @(posedge clk);
        for (int c = 1; c <= fin + 1; c++) begin
            @(negedge clk);
            ackx = !to && c >= s && c < s + 3 * nw;
            ph   = ackx ? (c - s) % 3 : 0;
            w    = ackx ? (c - s) / 3 : 0;
            chk("R2 R8 request", bus_req_n, !(c <= g), c);
            chk("R3 R6 R7 ack", bus_ack_n, !ackx, c);
            chk("R4 strobe", wr_stb_n, !(ackx && wr && ph == 1), c);
            chk("R5 oe", rd_oe_n, !(ackx && !wr), c);
            chk("R4 drive en", sys_dout_en, ackx && wr, c);
            if (ackx) chk("R7 word idx", word_idx, w, c);
            if (ackx && wr) chk("R4 data", sys_dout, wd(w) ^ salt, c);
            chk("R8 R9 fail", hs_fail_n, !(to && c > g), c);
            chk("R11 done", xfer_done, !to && c == s + 3 * nw, c);
            chk("R11 busy", busy, c < fin, c);
            chk("R5 valid", rd_valid, !to && !wr && c == s + 2, c);
            if (!to && !wr && c == s + 2) chk("R5 read data", rd_data, din_rec, c);
            // R10: mid-transfer start with scrambled attributes
            xfer_start = poke && (c == 3);
            if (poke && c == 3) begin
                xfer_write = !wr;
                xfer_burst = !bu;
                xfer_count = 6'd17;
            end
            bus_gnt_n = !(!to && c >= 1 + dly);
            sys_din   = 16'($urandom);
            if (c == s + 1) din_rec = sys_din;
        end
        xfer_start = 0;
        prev_to    = to;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (2) @(negedge clk);
        // R1
        chk("R1 req in reset", bus_req_n, 1, 0);
        chk("R1 fail in reset", hs_fail_n, 1, 0);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        @(negedge clk);
        chk("R1 req", bus_req_n, 1, 0);
        chk("R1 ack", bus_ack_n, 1, 0);
        chk("R1 strobe", wr_stb_n, 1, 0);
        chk("R1 oe", rd_oe_n, 1, 0);
        chk("R1 fail", hs_fail_n, 1, 0);
        chk("R1 drive en", sys_dout_en, 0, 0);
        chk("R1 busy", busy, 0, 0);
        chk("R1 done", xfer_done, 0, 0);
        chk("R1 valid", rd_valid, 0, 0);
        run_xfer(1, 0, 1, 0, 0);          // R3 grant tied low
        run_xfer(0, 0, 1, 3, 0);          // R5 read
        run_xfer(0, 1, 7, 1, 0);          // R6 burst flag ignored on read
        run_xfer(1, 0, 9, 2, 0);          // R6 count ignored without burst
        run_xfer(1, 1, 5, 0, 1);          // R7 R10 burst with mid start
        run_xfer(1, 1, 0, 1, 0);          // R7 count zero
        run_xfer(1, 1, 63, 0, 0);         // R7 largest count
        run_xfer(1, 1, 4, TMO - 1, 0);    // R8 grant on last edge wins
        run_xfer(0, 0, 1, TMO + 5, 0);    // R8 timeout
        run_xfer(1, 1, 3, 2, 0);          // R9 recovery after timeout
        run_xfer(1, 0, 1, TMO + 5, 1);    // R10 start during request
        run_xfer(0, 0, 1, 0, 1);          // R9 R10
        for (int i = 0; i < 40; i++) begin
            run_xfer(1'($urandom), 1'($urandom), int'($urandom % 64),
                     int'($urandom % 6), 1'($urandom));
        end
        finished = 1;
        summary();
        $finish;
    end
endmodule